// File: doc/BRIEF.md
# Quad Trim Register Serial Controller

The block is a serial slave that holds four 8-bit trim settings. Each channel has a working register whose value drives that channel's output code. Each channel also has a stored copy that stands in for nonvolatile memory. A host drives the serial clock, a chip-select level and one data-in line. Through these it can overwrite a working value, read a stored value back on the data-out line, or commit a working value into storage. A commit takes a fixed number of clock cycles and is flagged as busy while it runs.

Every frame opens with a high start bit. A 2-bit opcode follows, then a 2-bit channel address, then 8 data bits. All fields arrive least-significant bit first, and every bit is sampled on a rising clock edge. Dropping chip select abandons any frame in progress, floats data-out and restores every working register from its stored copy. A power-on reset yields the same state: storage takes its default value and every output follows it.

Top module: `quad_trim_ctrl`

## Requirements
- R1: After reset all four output codes equal the default code 0x80, busy is low and data-out is low.
- R2: While chip select is high and no frame is open, clock edges that sample data-in low are ignored. The first high sample opens a frame. The frame then takes 12 more bits: opcode bit 0, opcode bit 1, address bit A0, address bit A1, then data bits 0 to 7.
- R3: The address value is A0 + 2*A1. It selects a channel as follows: A0=0,A1=0 selects channel 1 (code bits 7:0), A0=1,A1=0 selects channel 2 (bits 15:8), A0=0,A1=1 selects channel 3 (bits 23:16) and A0=1,A1=1 selects channel 4 (bits 31:24).
- R4: Opcode value 0 (write) loads the data byte into the addressed working register. The new code appears on the edge that samples the last data bit.
- R5: Opcode value 1 (read) drives bit 0 of the addressed stored value on data-out from the edge that samples A1 onward. Each following edge presents the next bit, through bit 7. At all other times data-out is low. No output code changes.
- R6: Opcode value 2 (commit) raises busy on the edge that samples the last data bit. Busy stays high for 16 edges. On the 16th edge the stored value takes the working value that the register held when the commit was accepted, and busy falls on that same edge.
- R7: A commit frame that completes while busy is high has no effect on storage or on busy.
- R8: Opcode value 3 has no effect on any output code, on storage or on busy.
- R9: The two edges that follow the last bit of a frame ignore data-in, so a start bit on either of them opens no frame. A start bit on the third edge is accepted.
- R10: Every edge with chip select low copies each stored value into its working register. It also abandons any partial frame and clears the read-out.
- R11: The data-out enable equals chip select, so data-out is driven only while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs | input | 1 | Chip select, high enables transfers |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (stored value during a read) |
| sdo_oe | output | 1 | Drive enable for data-out; low means high impedance |
| busy | output | 1 | High while a commit is in progress |
| code | output | 32 | Four 8-bit output codes, channel 1 in the low byte |

## Verification
The hardest case to reach is a commit frame that completes while an earlier commit still has exactly one cycle left. That same edge must also leave storage alone. The stimulus gets there by sending the second commit frame after the minimum gap of two idle cycles. With a 13-bit frame and a 16-cycle commit, that frame's last bit then lands on the final busy cycle. A second race is a start bit that arrives on the last gap cycle with only zero bits behind it. The stimulus sends it and then confirms that the addressed output is unchanged. A frame cut short by chip select going low is checked the same way.

// File: rtl/qtr_pkg.sv
package qtr_pkg;
  typedef enum logic [1:0] {
    OP_WR  = 2'b00,
    OP_RD  = 2'b01,
    OP_CM  = 2'b10,
    OP_NOP = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SHIFT = 2'b01,
    ST_GAP   = 2'b10
  } rx_st_e;
endpackage

// File: rtl/qtr_frame_rx.sv
module qtr_frame_rx
  import qtr_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int ADDR_W  = 2,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sdi,
  output logic              cmd_fire,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CODE_W-1:0] cmd_data,
  output logic              rd_load,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int PAY  = 2 + ADDR_W + CODE_W;
  localparam int CW   = $clog2(PAY + 1);
  localparam int GW   = $clog2(GAP_CYC + 2);
  localparam int AEND = 2 + ADDR_W - 1;

  rx_st_e            st_q, st_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [GW-1:0]     gap_q, gap_n;
  logic [1:0]        op_q, op_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CODE_W-1:0] data_q, data_n;
  logic              shifting;

  assign shifting = (st_q == ST_SHIFT) && cs;
  assign cmd_fire = shifting && (cnt_q == CW'(PAY - 1));
  assign cmd_op   = op_e'(op_q);
  assign cmd_addr = addr_q;
  assign cmd_data = {sdi, data_q[CODE_W-1:1]};
  assign rd_load  = shifting && (cnt_q == CW'(AEND)) && (op_q == OP_RD);

  always_comb begin
    rd_addr = addr_q;
    rd_addr[ADDR_W-1] = sdi;
  end

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    gap_n  = gap_q;
    op_n   = op_q;
    addr_n = addr_q;
    data_n = data_q;
    if (!cs) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      gap_n = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (sdi) begin
            st_n  = ST_SHIFT;
            cnt_n = '0;
          end
        end
        ST_SHIFT: begin
          if (cnt_q == CW'(0)) op_n[0] = sdi;
          if (cnt_q == CW'(1)) op_n[1] = sdi;
          for (int i = 0; i < ADDR_W; i++) begin
            if (cnt_q == CW'(2 + i)) addr_n[i] = sdi;
          end
          if (cnt_q > CW'(AEND)) data_n = {sdi, data_q[CODE_W-1:1]};
          if (cnt_q == CW'(PAY - 1)) begin
            st_n  = (GAP_CYC == 0) ? ST_IDLE : ST_GAP;
            gap_n = GW'(GAP_CYC);
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        ST_GAP: begin
          if (gap_q <= GW'(1)) begin
            st_n  = ST_IDLE;
            gap_n = '0;
          end else begin
            gap_n = gap_q - GW'(1);
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      gap_q  <= '0;
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      gap_q  <= gap_n;
      op_q   <= op_n;
      addr_q <= addr_n;
      data_q <= data_n;
    end
  end

  // R9: a gap cycle never opens a frame
  a_r9_gap_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |=> (st_q != ST_SHIFT));

  // R2: low samples while idle keep the receiver idle
  a_r2_idle_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && cs && !sdi) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/qtr_trim_bank.sv
module qtr_trim_bank
  import qtr_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int CODE_W     = 8,
  parameter int ADDR_W     = 2,
  parameter int COMMIT_CYC = 16,
  parameter logic [CODE_W-1:0] INIT_CODE = 'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs,
  input  logic                  cmd_fire,
  input  op_e                   cmd_op,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [CODE_W-1:0]     cmd_data,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic [NCH*CODE_W-1:0] stored_o,
  output logic                  busy_o
);
  localparam int TW = $clog2(COMMIT_CYC + 1);

  logic [CODE_W-1:0] work_q [NCH];
  logic [CODE_W-1:0] work_n [NCH];
  logic [CODE_W-1:0] stor_q [NCH];
  logic [CODE_W-1:0] stor_n [NCH];
  logic [TW-1:0]     tmr_q, tmr_n;
  logic [ADDR_W-1:0] pch_q, pch_n;
  logic [CODE_W-1:0] pval_q, pval_n;

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign code_o[g*CODE_W +: CODE_W]   = work_q[g];
    assign stored_o[g*CODE_W +: CODE_W] = stor_q[g];
  end
  assign busy_o = (tmr_q != '0);

  always_comb begin
    work_n = work_q;
    stor_n = stor_q;
    tmr_n  = tmr_q;
    pch_n  = pch_q;
    pval_n = pval_q;
    if (!cs) begin
      for (int i = 0; i < NCH; i++) work_n[i] = stor_q[i];
    end else if (cmd_fire && cmd_op == OP_WR) begin
      work_n[cmd_addr] = cmd_data;
    end
    if (tmr_q != '0) begin
      tmr_n = tmr_q - TW'(1);
      if (tmr_q == TW'(1)) stor_n[pch_q] = pval_q;
    end else if (cmd_fire && cmd_op == OP_CM) begin
      tmr_n  = TW'(COMMIT_CYC);
      pch_n  = cmd_addr;
      pval_n = work_q[cmd_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        work_q[i] <= INIT_CODE;
        stor_q[i] <= INIT_CODE;
      end
      tmr_q  <= '0;
      pch_q  <= '0;
      pval_q <= '0;
    end else begin
      work_q <= work_n;
      stor_q <= stor_n;
      tmr_q  <= tmr_n;
      pch_q  <= pch_n;
      pval_q <= pval_n;
    end
  end

  // R7: a commit during busy does not restart the timer
  a_r7_busy_ignores_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q != '0 && cmd_fire && cmd_op == OP_CM) |=> (tmr_q == $past(tmr_q) - TW'(1)));

  // R6: storage moves only on the last busy cycle
  a_r6_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q != TW'(1)) |=> $stable(stored_o));

  // R10: chip select low restores outputs from storage
  a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs) |=> (code_o == $past(stored_o)));

  // R5: a read leaves every output code alone
  a_r5_read_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && cmd_fire && cmd_op == OP_RD) |=> $stable(code_o));

  // R8: the unused opcode leaves every output code alone
  a_r8_nop_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && cmd_fire && cmd_op == OP_NOP) |=> $stable(code_o));
endmodule

// File: rtl/qtr_readback.sv
module qtr_readback #(
  parameter int NCH    = 4,
  parameter int CODE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs,
  input  logic                  rd_load,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [NCH*CODE_W-1:0] stored_i,
  output logic                  sdo
);
  logic [CODE_W-1:0] sr_q, sr_n;

  assign sdo = sr_q[0];

  always_comb begin
    if (!cs)          sr_n = '0;
    else if (rd_load) sr_n = stored_i[int'(rd_addr)*CODE_W +: CODE_W];
    else              sr_n = {1'b0, sr_q[CODE_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_n;
  end

  // R5: data-out stays low on the edge after an unselected cycle
  a_r5_sdo_quiet_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs) |=> !sdo);
endmodule

// File: rtl/quad_trim_ctrl.sv
module quad_trim_ctrl
  import qtr_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int CODE_W     = 8,
  parameter int COMMIT_CYC = 16,
  parameter int GAP_CYC    = 2,
  parameter logic [CODE_W-1:0] INIT_CODE = 'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  sdo_oe,
  output logic                  busy,
  output logic [NCH*CODE_W-1:0] code
);
  localparam int ADDR_W = $clog2(NCH);

  logic [1:0]            rs_q;
  logic                  rst_i;
  logic                  cmd_fire;
  op_e                   cmd_op;
  logic [ADDR_W-1:0]     cmd_addr;
  logic [CODE_W-1:0]     cmd_data;
  logic                  rd_load;
  logic [ADDR_W-1:0]     rd_addr;
  logic [NCH*CODE_W-1:0] stored;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i  = rs_q[1];
  assign sdo_oe = cs;

  qtr_frame_rx #(
    .CODE_W(CODE_W), .ADDR_W(ADDR_W), .GAP_CYC(GAP_CYC)
  ) u_rx (
    .clk(clk), .rst_n(rst_i), .cs(cs), .sdi(sdi),
    .cmd_fire(cmd_fire), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_load(rd_load), .rd_addr(rd_addr)
  );

  qtr_trim_bank #(
    .NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W),
    .COMMIT_CYC(COMMIT_CYC), .INIT_CODE(INIT_CODE)
  ) u_bank (
    .clk(clk), .rst_n(rst_i), .cs(cs),
    .cmd_fire(cmd_fire), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .code_o(code), .stored_o(stored), .busy_o(busy)
  );

  qtr_readback #(
    .NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)
  ) u_rb (
    .clk(clk), .rst_n(rst_i), .cs(cs), .rd_load(rd_load),
    .rd_addr(rd_addr), .stored_i(stored), .sdo(sdo)
  );
endmodule

// File: tb/sim_quad_trim_ctrl.sv
`timescale 1ns/1ps
module sim_quad_trim_ctrl;
  localparam int COMMIT = 16;
  localparam int GAP    = 2;

  logic        clk = 1'b0;
  logic        rst_n, cs, sdi;
  logic        sdo, sdo_oe, busy;
  logic [31:0] code;

  quad_trim_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .code(code)
  );

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // behavioural reference model
  int m_work[4], m_stor[4], os[4];
  int m_cnt, m_pch, m_pval, m_gap, rs;
  bit m_in, m_sdo;
  bit qb[$];
  bit rdq[$];

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_work[i] = 'h80; m_stor[i] = 'h80; end
    m_cnt = 0; m_pch = 0; m_pval = 0; m_gap = 0; m_in = 0; m_sdo = 0;
    qb.delete(); rdq.delete();
  endtask

  task automatic model_step();
    bit fire;
    int op, ad, dt;
    fire = 0; op = 0; ad = 0; dt = 0;
    for (int i = 0; i < 4; i++) os[i] = m_stor[i];
    if (cs) begin
      if (m_gap > 0) m_gap--;
      else if (m_in) begin
        qb.push_back(sdi);
        if (qb.size() == 4 && qb[0] == 1 && qb[1] == 0) begin
          ad = qb[2] + 2 * qb[3];
          rdq.delete();
          for (int i = 0; i < 8; i++) rdq.push_back(bit'((os[ad] >> i) & 1));
        end
        if (qb.size() == 12) begin
          fire = 1;
          op = qb[0] + 2 * qb[1];
          ad = qb[2] + 2 * qb[3];
          for (int i = 0; i < 8; i++) dt = dt | (int'(qb[4+i]) << i);
          qb.delete(); m_in = 0; m_gap = GAP;
        end
      end else if (sdi) m_in = 1;
      if (rdq.size() > 0) m_sdo = rdq.pop_front(); else m_sdo = 0;
    end else begin
      m_in = 0; m_gap = 0; qb.delete(); rdq.delete(); m_sdo = 0;
    end
    if (m_cnt > 0) begin
      if (m_cnt == 1) m_stor[m_pch] = m_pval;
      m_cnt--;
    end else if (fire && op == 2) begin
      m_cnt = COMMIT; m_pch = ad; m_pval = m_work[ad];
    end
    if (!cs) for (int i = 0; i < 4; i++) m_work[i] = os[i];
    else if (fire && op == 0) m_work[ad] = dt;
  endtask

  always @(posedge clk) begin
    logic [31:0] ec;
    cyc++;
    if (!rst_n) begin model_reset(); rs = 0; end
    else if (rs < 2) rs++;
    else model_step();
    #1;
    for (int i = 0; i < 4; i++) ec[i*8 +: 8] = m_work[i][7:0];
    chk("R4 code", code, ec);
    chk("R6 busy", {31'd0, busy}, {31'd0, m_cnt != 0});
    chk("R5 sdo", {31'd0, sdo}, {31'd0, m_sdo});
    chk("R11 sdo_oe", {31'd0, sdo_oe}, {31'd0, cs});
    if (cyc > 50000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); sdi = 1'b0; end
  endtask

  task automatic frame(int op, int ad, int dt, output logic [7:0] rd);
    bit b[13];
    b[0] = 1; b[1] = op[0]; b[2] = op[1]; b[3] = ad[0]; b[4] = ad[1];
    for (int i = 0; i < 8; i++) b[5+i] = dt[i];
    rd = '0;
    for (int k = 0; k < 13; k++) begin
      @(negedge clk);
      if (k >= 5) rd[k-5] = sdo;
      sdi = b[k];
    end
  endtask

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; cs = 1'b0; sdi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 codes", code, 32'h80808080);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 sdo", {31'd0, sdo}, 32'd0);
    @(negedge clk); cs = 1'b1;
    idle(5);
    chk("R2 low bits ignored", code, 32'h80808080);
    frame(0, 0, 'h5A, rd); idle(2);
    chk("R4 write ch1", {24'd0, code[7:0]}, 32'h5A);
    frame(0, 1, 'h11, rd); idle(2);
    chk("R3 A0=1 ch2", {24'd0, code[15:8]}, 32'h11);
    frame(0, 2, 'h22, rd); idle(2);
    chk("R3 A1=1 ch3", {24'd0, code[23:16]}, 32'h22);
    frame(0, 3, 'h33, rd); idle(2);
    chk("R3 both ch4", code, 32'h3322115A);
    frame(2, 1, 0, rd); idle(2);
    chk("R6 busy during commit", {31'd0, busy}, 32'd1);
    frame(2, 2, 0, rd); idle(2);
    idle(20);
    chk("R6 busy ends", {31'd0, busy}, 32'd0);
    frame(1, 1, 'hFF, rd); idle(2);
    chk("R5 readback ch2", {24'd0, rd}, 32'h11);
    chk("R5 codes unchanged", code, 32'h3322115A);
    frame(1, 2, 0, rd); idle(2);
    chk("R7 ignored commit", {24'd0, rd}, 32'h80);
    frame(3, 0, 'hFF, rd); idle(2);
    chk("R8 nop codes", code, 32'h3322115A);
    chk("R8 nop busy", {31'd0, busy}, 32'd0);
    frame(0, 0, 'h66, rd); idle(1);
    frame(0, 0, 'h00, rd); idle(2);
    chk("R9 early start ignored", {24'd0, code[7:0]}, 32'h66);
    frame(0, 0, 'h77, rd); idle(2);
    chk("R9 third edge accepted", {24'd0, code[7:0]}, 32'h77);
    @(negedge clk); sdi = 1; @(negedge clk); sdi = 0;
    @(negedge clk); sdi = 0; @(negedge clk); sdi = 0;
    @(negedge clk); cs = 1'b0;
    idle(2);
    chk("R10 reload from storage", code, 32'h80801180);
    chk("R11 oe low", {31'd0, sdo_oe}, 32'd0);
    @(negedge clk); cs = 1'b1;
    idle(2);
    chk("R11 oe high", {31'd0, sdo_oe}, 32'd1);
    chk("R10 partial frame dropped", code, 32'h80801180);
    finish_run();
  end
endmodule